// File: doc/BRIEF.md
# Display Controller Extended Register and Bank Window Port

This block is the byte-wide host I/O slave that holds the graphics-controller and CRT-controller register files of a VGA-compatible display controller. Each file is reached through an index/data port pair. The block also holds two memory bank registers, and from them it derives the 64 KB read and write window offsets that the memory path adds to host addresses. Two strap inputs give a chip-type code and an installed-memory code. Neither is stored: both are merged into specific register reads.

The CRT-controller ports, the bank ports and all other ports in the 0x3B0–0x3BF and 0x3D0–0x3DF ranges move between the monochrome and colour address ranges. A colour-select bit in the miscellaneous output register picks the range. A protect bit fences off the horizontal timing registers. An unlock bit gates reads of the extended CRT-controller registers, and it also decides whether a write can change the display address mask. Every access completes in one cycle, and read data appears on the cycle after the read strobe.

Top module: `svga_ext_regs`

## Requirements
- R1: After reset every register is zero except the miscellaneous output register, which reads 0x01 (colour mapping). Both bank offsets are zero, the display mask is 0x3FFFF and the read data output is 0x00.
- R2: The miscellaneous output register is written at 0x3C2 and read at 0x3CC. When its bit 0 is 0, any access whose address lies in 0x3B0–0x3BF or 0x3D0–0x3DF has its address XORed with 0x60 before decoding.
- R3: The write bank offset equals bits 3:0 of the bank register at port 0x3D7, multiplied by 65536.
- R4: The read bank offset equals bits 3:0 of the bank register at port 0x3D6, multiplied by 65536, when bit 2 of graphics register 0x0F is set. Otherwise it equals the write bank offset. Both bank registers read back all 8 bits.
- R5: A write to the CRT-controller index port 0x3D4 stores only data bits 5:0. The port reads back that index with bits 7:6 zero.
- R6: While bit 7 of CRT-controller register 0x11 is set, writes to CRT-controller registers 0 to 6 leave them unchanged.
- R7: While bit 7 of CRT-controller register 0x11 is set, a write to CRT-controller register 7 changes only bit 4.
- R8: While bit 7 of CRT-controller register 0x1E is clear, a read of any CRT-controller index above 0x18 returns 0xFF.
- R9: When unlocked, a read of CRT-controller register 0x1A returns the 2-bit chip type input in bits 7:6, with bits 5:0 zero.
- R10: When unlocked, a read of CRT-controller register 0x1E returns the stored value ORed with a memory code. The code is 1 for memSize 1 (512 KB), 0 for memSize 0 (256 KB), and 2 for memSize 2 or 3 (1 MB).
- R11: The graphics index port 0x3CE stores all 8 bits. Data port 0x3CF reads and writes the register selected by the index when the index is below 64, and reads 0x00 otherwise. A read of graphics register 0x0C always has bit 2 set.
- R12: A write to CRT-controller register 0x19 made while unlocked sets the display mask. The mask becomes the full memory mask (0x3FFFF, 0x7FFFF or 0xFFFFF for memSize 0, 1, 2 or 3) when data bit 5 is 1, and 0x3FFFF when it is 0. At other times the mask holds its value.
- R13: Read data is registered one cycle after a read strobe and holds its value while no read occurs. A read of an undecoded port returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Host write strobe, one cycle per access |
| ioRd | input | 1 | Host read strobe, one cycle per access |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWdata | input | 8 | Host write data |
| ioRdata | output | 8 | Registered host read data |
| chipType | input | 2 | Strap: chip type code |
| memSize | input | 2 | Strap: installed memory, 0=256 KB, 1=512 KB, 2/3=1 MB |
| readBankOfs | output | BANK_BITS+BANK_SHIFT | Byte offset of the read bank window |
| writeBankOfs | output | BANK_BITS+BANK_SHIFT | Byte offset of the write bank window |
| dispMask | output | BANK_BITS+BANK_SHIFT | Display address mask |

## Verification
The assertions check on every cycle that the read bank tracks the write bank while the banks are not split, and that a bank write or an index write lands on the next cycle. They also check that locked extended reads return 0xFF, that chip-type reads carry the strap value, and that read data is stable between reads. Write protection of registers 0–7, the memory-code merge, mask selection under lock and unlock, the graphics 0x0C readback and address relocation in monochrome mode can be shown only by the bench. It runs directed sequences and a randomized register mix against a reference model.

// File: rtl/svga_ext_pkg.sv
package svga_ext_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_GDC_IDX,
    RD_GDC_DATA,
    RD_CRTC_IDX,
    RD_CRTC_DATA,
    RD_BANK_RD,
    RD_BANK_WR,
    RD_MISC
  } rdSel_e;

  typedef struct packed {
    logic       gdcIdxWr;
    logic       gdcDataWr;
    logic       crtcIdxWr;
    logic       crtcDataWr;
    logic [7:0] crtcKeepMask;   // bits of the old CRTC value kept on a data write
    logic       bankRdWr;
    logic       bankWrWr;
    logic       miscWr;
    logic       rdEn;
    rdSel_e     rdSel;
  } regStrobe_t;

  localparam logic [15:0] PORT_MISC_WR  = 16'h03C2;
  localparam logic [15:0] PORT_MISC_RD  = 16'h03CC;
  localparam logic [15:0] PORT_GDC_IDX  = 16'h03CE;
  localparam logic [15:0] PORT_GDC_DATA = 16'h03CF;
  localparam logic [15:0] PORT_CRTC_IDX = 16'h03D4;
  localparam logic [15:0] PORT_CRTC_DAT = 16'h03D5;
  localparam logic [15:0] PORT_BANK_RD  = 16'h03D6;
  localparam logic [15:0] PORT_BANK_WR  = 16'h03D7;
  localparam logic [15:0] RANGE_COLOUR  = 16'h03D0;
  localparam logic [15:0] RANGE_MONO    = 16'h03B0;
  localparam logic [15:0] RELOC_XOR     = 16'h0060;

  localparam logic [7:0] CRTC_PROT_IDX   = 8'h11;
  localparam logic [7:0] CRTC_LAST_STD   = 8'h18;
  localparam logic [7:0] CRTC_MODE_IDX   = 8'h19;
  localparam logic [7:0] CRTC_CHIP_IDX   = 8'h1A;
  localparam logic [7:0] CRTC_UNLOCK_IDX = 8'h1E;
  localparam logic [7:0] GDC_TIMING_IDX  = 8'h0C;
  localparam logic [7:0] GDC_BANKCFG_IDX = 8'h0F;

endpackage

// File: rtl/svga_ext_ctrl.sv
module svga_ext_ctrl
  import svga_ext_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CRTC_IDX_W = 6
) (
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic [ADDR_W-1:0]     ioAddr,
  input  logic                  miscColour,
  input  logic [CRTC_IDX_W-1:0] crtcIdx,
  input  logic                  crtcProtect,
  output regStrobe_t            strobe
);

  localparam logic [ADDR_W-1:0] HI_MASK = ~ADDR_W'(16'h000F);

  logic [ADDR_W-1:0] effAddr;
  logic              inRelocRange;

  always_comb begin
    inRelocRange = ((ioAddr & HI_MASK) == ADDR_W'(RANGE_COLOUR)) ||
                   ((ioAddr & HI_MASK) == ADDR_W'(RANGE_MONO));
    effAddr = (!miscColour && inRelocRange) ? (ioAddr ^ ADDR_W'(RELOC_XOR)) : ioAddr;
  end

  logic hitMiscWr, hitMiscRd, hitGdcIdx, hitGdcData;
  logic hitCrtcIdx, hitCrtcData, hitBankRd, hitBankWr;

  always_comb begin
    hitMiscWr   = effAddr == ADDR_W'(PORT_MISC_WR);
    hitMiscRd   = effAddr == ADDR_W'(PORT_MISC_RD);
    hitGdcIdx   = effAddr == ADDR_W'(PORT_GDC_IDX);
    hitGdcData  = effAddr == ADDR_W'(PORT_GDC_DATA);
    hitCrtcIdx  = effAddr == ADDR_W'(PORT_CRTC_IDX);
    hitCrtcData = effAddr == ADDR_W'(PORT_CRTC_DAT);
    hitBankRd   = effAddr == ADDR_W'(PORT_BANK_RD);
    hitBankWr   = effAddr == ADDR_W'(PORT_BANK_WR);
  end

  logic [7:0] keepMask;

  always_comb begin
    keepMask = 8'h00;
    if (crtcProtect) begin
      if (crtcIdx < CRTC_IDX_W'(7))       keepMask = 8'hFF;
      else if (crtcIdx == CRTC_IDX_W'(7)) keepMask = 8'hEF;
    end
  end

  always_comb begin
    strobe              = '0;
    strobe.rdSel        = RD_NONE;
    strobe.crtcKeepMask = keepMask;
    strobe.miscWr       = ioWr && hitMiscWr;
    strobe.gdcIdxWr     = ioWr && hitGdcIdx;
    strobe.gdcDataWr    = ioWr && hitGdcData;
    strobe.crtcIdxWr    = ioWr && hitCrtcIdx;
    strobe.crtcDataWr   = ioWr && hitCrtcData && (keepMask != 8'hFF);
    strobe.bankRdWr     = ioWr && hitBankRd;
    strobe.bankWrWr     = ioWr && hitBankWr;
    strobe.rdEn         = ioRd;
    if (hitMiscRd)        strobe.rdSel = RD_MISC;
    else if (hitGdcIdx)   strobe.rdSel = RD_GDC_IDX;
    else if (hitGdcData)  strobe.rdSel = RD_GDC_DATA;
    else if (hitCrtcIdx)  strobe.rdSel = RD_CRTC_IDX;
    else if (hitCrtcData) strobe.rdSel = RD_CRTC_DATA;
    else if (hitBankRd)   strobe.rdSel = RD_BANK_RD;
    else if (hitBankWr)   strobe.rdSel = RD_BANK_WR;
  end

endmodule

// File: rtl/svga_ext_dp.sv
module svga_ext_dp
  import svga_ext_pkg::*;
#(
  parameter int CRTC_DEPTH = 64,
  parameter int GDC_DEPTH  = 64,
  parameter int BANK_BITS  = 4,
  parameter int BANK_SHIFT = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  regStrobe_t                      strobe,
  input  logic [7:0]                      ioWdata,
  input  logic [1:0]                      chipType,
  input  logic [1:0]                      memSize,
  output logic [7:0]                      ioRdata,
  output logic [$clog2(CRTC_DEPTH)-1:0]   crtcIdx,
  output logic                            crtcProtect,
  output logic                            crtcUnlock,
  output logic                            miscColour,
  output logic                            splitBanks,
  output logic [BANK_BITS+BANK_SHIFT-1:0] readBankOfs,
  output logic [BANK_BITS+BANK_SHIFT-1:0] writeBankOfs,
  output logic [BANK_BITS+BANK_SHIFT-1:0] dispMask
);

  localparam int CRTC_IDX_W = $clog2(CRTC_DEPTH);
  localparam int GDC_IDX_W  = $clog2(GDC_DEPTH);
  localparam int OFS_W      = BANK_BITS + BANK_SHIFT;
  localparam logic [OFS_W-1:0] BASE_MASK = OFS_W'(20'h3FFFF);

  logic [7:0] crtcRegs [CRTC_DEPTH];
  logic [7:0] gdcRegs  [GDC_DEPTH];
  logic [7:0] gdcIdx;
  logic [7:0] bankRd, bankWr, miscReg;

  logic [7:0] crtcCur, crtcNext;
  logic       gdcInRange;

  always_comb begin
    crtcCur    = crtcRegs[crtcIdx];
    crtcNext   = (crtcCur & strobe.crtcKeepMask) | (ioWdata & ~strobe.crtcKeepMask);
    gdcInRange = int'(gdcIdx) < GDC_DEPTH;
  end

  assign crtcProtect = crtcRegs[CRTC_IDX_W'(CRTC_PROT_IDX)][7];
  assign crtcUnlock  = crtcRegs[CRTC_IDX_W'(CRTC_UNLOCK_IDX)][7];
  assign miscColour  = miscReg[0];
  assign splitBanks  = gdcRegs[GDC_IDX_W'(GDC_BANKCFG_IDX)][2];

  // Memory strap decode
  logic [1:0]       memCode;
  logic [OFS_W-1:0] fullMask;

  always_comb begin
    unique case (memSize)
      2'd0:    begin memCode = 2'd0; fullMask = OFS_W'(20'h3FFFF); end
      2'd1:    begin memCode = 2'd1; fullMask = OFS_W'(20'h7FFFF); end
      default: begin memCode = 2'd2; fullMask = OFS_W'(20'hFFFFF); end
    endcase
  end

  // Register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CRTC_DEPTH; i++) crtcRegs[i] <= '0;
      for (int i = 0; i < GDC_DEPTH; i++)  gdcRegs[i]  <= '0;
      crtcIdx  <= '0;
      gdcIdx   <= '0;
      bankRd   <= '0;
      bankWr   <= '0;
      miscReg  <= 8'h01;
      dispMask <= BASE_MASK;
    end else begin
      if (strobe.miscWr)    miscReg <= ioWdata;
      if (strobe.gdcIdxWr)  gdcIdx  <= ioWdata;
      if (strobe.crtcIdxWr) crtcIdx <= ioWdata[CRTC_IDX_W-1:0];
      if (strobe.bankRdWr)  bankRd  <= ioWdata;
      if (strobe.bankWrWr)  bankWr  <= ioWdata;
      if (strobe.gdcDataWr && gdcInRange)
        gdcRegs[gdcIdx[GDC_IDX_W-1:0]] <= ioWdata;
      if (strobe.crtcDataWr) begin
        crtcRegs[crtcIdx] <= crtcNext;
        if (crtcIdx == CRTC_IDX_W'(CRTC_MODE_IDX) && crtcUnlock)
          dispMask <= crtcNext[5] ? fullMask : BASE_MASK;
      end
    end
  end

  // Bank window offsets
  always_comb begin
    writeBankOfs = {bankWr[BANK_BITS-1:0], {BANK_SHIFT{1'b0}}};
    readBankOfs  = splitBanks ? {bankRd[BANK_BITS-1:0], {BANK_SHIFT{1'b0}}}
                              : writeBankOfs;
  end

  // Readback
  logic [7:0] crtcView, gdcView, rdValue;

  always_comb begin
    if (!crtcUnlock && (crtcIdx > CRTC_IDX_W'(CRTC_LAST_STD)))
      crtcView = 8'hFF;
    else if (crtcIdx == CRTC_IDX_W'(CRTC_CHIP_IDX))
      crtcView = {chipType, 6'b0};
    else if (crtcIdx == CRTC_IDX_W'(CRTC_UNLOCK_IDX))
      crtcView = crtcCur | {6'b0, memCode};
    else
      crtcView = crtcCur;

    if (!gdcInRange)
      gdcView = 8'h00;
    else if (gdcIdx == GDC_TIMING_IDX)
      gdcView = gdcRegs[gdcIdx[GDC_IDX_W-1:0]] | 8'h04;
    else
      gdcView = gdcRegs[gdcIdx[GDC_IDX_W-1:0]];

    unique case (strobe.rdSel)
      RD_MISC:      rdValue = miscReg;
      RD_GDC_IDX:   rdValue = gdcIdx;
      RD_GDC_DATA:  rdValue = gdcView;
      RD_CRTC_IDX:  rdValue = 8'(crtcIdx);
      RD_CRTC_DATA: rdValue = crtcView;
      RD_BANK_RD:   rdValue = bankRd;
      RD_BANK_WR:   rdValue = bankWr;
      default:      rdValue = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ioRdata <= '0;
    else if (strobe.rdEn) ioRdata <= rdValue;
  end

endmodule

// File: rtl/svga_ext_regs.sv
module svga_ext_regs
  import svga_ext_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CRTC_DEPTH = 64,
  parameter int GDC_DEPTH  = 64,
  parameter int BANK_BITS  = 4,
  parameter int BANK_SHIFT = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            ioWr,
  input  logic                            ioRd,
  input  logic [ADDR_W-1:0]               ioAddr,
  input  logic [7:0]                      ioWdata,
  output logic [7:0]                      ioRdata,
  input  logic [1:0]                      chipType,
  input  logic [1:0]                      memSize,
  output logic [BANK_BITS+BANK_SHIFT-1:0] readBankOfs,
  output logic [BANK_BITS+BANK_SHIFT-1:0] writeBankOfs,
  output logic [BANK_BITS+BANK_SHIFT-1:0] dispMask
);

  localparam int CRTC_IDX_W = $clog2(CRTC_DEPTH);

  regStrobe_t            strobe;
  logic [CRTC_IDX_W-1:0] crtcIdx;
  logic                  crtcProtect, crtcUnlock, miscColour, splitBanks;

  svga_ext_ctrl #(
    .ADDR_W    (ADDR_W),
    .CRTC_IDX_W(CRTC_IDX_W)
  ) ctrl_i (
    .ioWr       (ioWr),
    .ioRd       (ioRd),
    .ioAddr     (ioAddr),
    .miscColour (miscColour),
    .crtcIdx    (crtcIdx),
    .crtcProtect(crtcProtect),
    .strobe     (strobe)
  );

  svga_ext_dp #(
    .CRTC_DEPTH(CRTC_DEPTH),
    .GDC_DEPTH (GDC_DEPTH),
    .BANK_BITS (BANK_BITS),
    .BANK_SHIFT(BANK_SHIFT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ioWdata     (ioWdata),
    .chipType    (chipType),
    .memSize     (memSize),
    .ioRdata     (ioRdata),
    .crtcIdx     (crtcIdx),
    .crtcProtect (crtcProtect),
    .crtcUnlock  (crtcUnlock),
    .miscColour  (miscColour),
    .splitBanks  (splitBanks),
    .readBankOfs (readBankOfs),
    .writeBankOfs(writeBankOfs),
    .dispMask    (dispMask)
  );

endmodule

// File: rtl/svga_ext_regs_chk.sv
module svga_ext_regs_chk #(
  parameter int ADDR_W     = 16,
  parameter int CRTC_IDX_W = 6,
  parameter int BANK_BITS  = 4,
  parameter int BANK_SHIFT = 16
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            ioWr,
  input logic                            ioRd,
  input logic [ADDR_W-1:0]               ioAddr,
  input logic [5:0]                      wdLow,
  input logic [7:0]                      ioRdata,
  input logic [1:0]                      chipType,
  input logic [BANK_BITS+BANK_SHIFT-1:0] readBankOfs,
  input logic [BANK_BITS+BANK_SHIFT-1:0] writeBankOfs,
  input logic                            miscColour,
  input logic                            splitBanks,
  input logic [CRTC_IDX_W-1:0]           crtcIdx,
  input logic                            crtcUnlock
);

  localparam int OFS_W = BANK_BITS + BANK_SHIFT;

  logic colourCrtcData;
  assign colourCrtcData = ioRd && miscColour && ioAddr == ADDR_W'(16'h03D5);

  // R3
  wbank_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioWr && miscColour && ioAddr == ADDR_W'(16'h03D7)
    |=> writeBankOfs[OFS_W-1:BANK_SHIFT] == $past(wdLow[BANK_BITS-1:0]));

  // R4
  rbank_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !splitBanks |-> readBankOfs == writeBankOfs);

  // R5
  crtc_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioWr && miscColour && ioAddr == ADDR_W'(16'h03D4)
    |=> crtcIdx == $past(wdLow[CRTC_IDX_W-1:0]));

  // R8
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    colourCrtcData && !crtcUnlock && crtcIdx > CRTC_IDX_W'(8'h18)
    |=> ioRdata == 8'hFF);

  // R9
  chip_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    colourCrtcData && crtcUnlock && crtcIdx == CRTC_IDX_W'(8'h1A)
    |=> ioRdata == {$past(chipType), 6'b0});

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |=> $stable(ioRdata));

endmodule

bind svga_ext_regs svga_ext_regs_chk #(
  .ADDR_W    (ADDR_W),
  .CRTC_IDX_W(CRTC_IDX_W),
  .BANK_BITS (BANK_BITS),
  .BANK_SHIFT(BANK_SHIFT)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ioWr        (ioWr),
  .ioRd        (ioRd),
  .ioAddr      (ioAddr),
  .wdLow       (ioWdata[5:0]),
  .ioRdata     (ioRdata),
  .chipType    (chipType),
  .readBankOfs (readBankOfs),
  .writeBankOfs(writeBankOfs),
  .miscColour  (miscColour),
  .splitBanks  (splitBanks),
  .crtcIdx     (crtcIdx),
  .crtcUnlock  (crtcUnlock)
);

// File: tb/svga_ext_regs_tb.sv
`timescale 1ns/1ps
module svga_ext_regs_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ioWr, ioRd;
  logic [15:0] ioAddr;
  logic [7:0]  ioWdata;
  logic [7:0]  ioRdata;
  logic [1:0]  chipType, memSize;
  logic [19:0] readBankOfs, writeBankOfs, dispMask;

  always #2.5 clk = ~clk;

  svga_ext_regs dut_i (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .chipType(chipType), .memSize(memSize),
    .readBankOfs(readBankOfs), .writeBankOfs(writeBankOfs), .dispMask(dispMask)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [7:0]  mCrtc [64];
  logic [7:0]  mGdc  [64];
  logic [5:0]  mCrtcIdx;
  logic [7:0]  mGdcIdx, mBankR, mBankW, mMisc;
  logic [19:0] mMask;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  function automatic logic [15:0] reloc(logic [15:0] a);
    if (!mMisc[0] && ((a & 16'hFFF0) == 16'h03D0 || (a & 16'hFFF0) == 16'h03B0))
      return a ^ 16'h0060;
    return a;
  endfunction

  function automatic logic [19:0] fullMaskOf(logic [1:0] ms);
    return (ms == 2'd0) ? 20'h3FFFF : (ms == 2'd1) ? 20'h7FFFF : 20'hFFFFF;
  endfunction

  function automatic logic [7:0] mRead(logic [15:0] addr);
    logic [15:0] a = reloc(addr);
    logic [7:0]  v;
    case (a)
      16'h03CC: return mMisc;
      16'h03CE: return mGdcIdx;
      16'h03CF: begin
        if (mGdcIdx >= 8'd64) return 8'h00;
        v = mGdc[mGdcIdx[5:0]];
        return (mGdcIdx == 8'h0C) ? (v | 8'h04) : v;
      end
      16'h03D4: return {2'b00, mCrtcIdx};
      16'h03D5: begin
        if (!mCrtc[30][7] && mCrtcIdx > 6'h18) return 8'hFF;
        if (mCrtcIdx == 6'h1A) return {chipType, 6'b0};
        if (mCrtcIdx == 6'h1E)
          return mCrtc[30] | ((memSize == 2'd0) ? 8'd0 : (memSize == 2'd1) ? 8'd1 : 8'd2);
        return mCrtc[mCrtcIdx];
      end
      16'h03D6: return mBankR;
      16'h03D7: return mBankW;
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic mWrite(logic [15:0] addr, logic [7:0] d);
    logic [15:0] a = reloc(addr);
    logic [7:0]  v = d;
    logic        prot = mCrtc[17][7];
    case (a)
      16'h03C2: mMisc = d;
      16'h03CE: mGdcIdx = d;
      16'h03CF: if (mGdcIdx < 8'd64) mGdc[mGdcIdx[5:0]] = d;
      16'h03D4: mCrtcIdx = d[5:0];
      16'h03D5: begin
        if (!(prot && mCrtcIdx < 6'd7)) begin
          if (prot && mCrtcIdx == 6'd7) v = (mCrtc[7] & 8'hEF) | (d & 8'h10);
          if (mCrtcIdx == 6'h19 && mCrtc[30][7])
            mMask = v[5] ? fullMaskOf(memSize) : 20'h3FFFF;
          mCrtc[mCrtcIdx] = v;
        end
      end
      16'h03D6: mBankR = d;
      16'h03D7: mBankW = d;
      default: ;
    endcase
  endtask

  task automatic wr(logic [15:0] addr, logic [7:0] d);
    @(negedge clk);
    ioWr = 1'b1; ioAddr = addr; ioWdata = d;
    @(negedge clk);
    ioWr = 1'b0;
    mWrite(addr, d);
  endtask

  task automatic rd(logic [15:0] addr, string tag);
    logic [7:0] exp = mRead(addr);
    @(negedge clk);
    ioRd = 1'b1; ioAddr = addr;
    @(negedge clk);
    ioRd = 1'b0;
    chk(tag, 32'(ioRdata), 32'(exp));
  endtask

  task automatic outs(string tag);
    chk({tag, " R3 writeBank"}, 32'(writeBankOfs), 32'({mBankW[3:0], 16'h0}));
    chk({tag, " R4 readBank"}, 32'(readBankOfs),
        32'(mGdc[15][2] ? {mBankR[3:0], 16'h0} : {mBankW[3:0], 16'h0}));
    chk({tag, " R12 mask"}, 32'(dispMask), 32'(mMask));
  endtask

  task automatic crtcWr(logic [5:0] idx, logic [7:0] d);
    wr(16'h03D4, {2'b0, idx});
    wr(16'h03D5, d);
  endtask

  task automatic crtcRd(logic [5:0] idx, string tag);
    wr(16'h03D4, {2'b0, idx});
    rd(16'h03D5, tag);
  endtask

  initial begin
    rstN = 1'b0; ioWr = 1'b0; ioRd = 1'b0; ioAddr = '0; ioWdata = '0;
    chipType = 2'd3; memSize = 2'd2;
    for (int i = 0; i < 64; i++) begin mCrtc[i] = '0; mGdc[i] = '0; end
    mCrtcIdx = '0; mGdcIdx = '0; mBankR = '0; mBankW = '0; mMisc = 8'h01;
    mMask = 20'h3FFFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 rdata", 32'(ioRdata), 32'h0);
    outs("R1");
    rd(16'h03CC, "R1 misc");
    rd(16'h03D7, "R1 bankWr");

    // R6 / R7 write protection
    crtcWr(6'h03, 8'h5A);
    crtcWr(6'h11, 8'h80);
    crtcWr(6'h03, 8'hA5);
    crtcRd(6'h03, "R6 protected reg3");
    crtcWr(6'h07, 8'hFF);
    crtcRd(6'h07, "R7 protected reg7");
    crtcWr(6'h00, 8'h77);
    crtcRd(6'h00, "R6 protected reg0");
    crtcWr(6'h11, 8'h00);
    crtcWr(6'h03, 8'hA5);
    crtcRd(6'h03, "R6 unprotected reg3");

    // R5 index width
    wr(16'h03D4, 8'hC5);
    rd(16'h03D4, "R5 idx low6");

    // R8 locked extended reads
    crtcWr(6'h20, 8'h33);
    crtcRd(6'h20, "R8 locked 0x20");
    crtcRd(6'h1A, "R8 locked 0x1A");
    crtcRd(6'h18, "R8 std 0x18");

    // R12 mask ignored while locked
    crtcWr(6'h19, 8'h20);
    outs("R12 locked");

    // unlock: R9, R10, R12
    crtcWr(6'h1E, 8'h80);
    crtcRd(6'h1E, "R10 mem 1MB");
    memSize = 2'd1;
    crtcRd(6'h1E, "R10 mem 512K");
    memSize = 2'd0;
    crtcRd(6'h1E, "R10 mem 256K");
    memSize = 2'd2;
    crtcRd(6'h1A, "R9 chip 3");
    chipType = 2'd1;
    crtcRd(6'h1A, "R9 chip 1");
    crtcRd(6'h20, "R8 unlocked 0x20");
    crtcWr(6'h19, 8'h20);
    outs("R12 full");
    memSize = 2'd1;
    crtcWr(6'h19, 8'h20);
    outs("R12 512K");
    crtcWr(6'h19, 8'h00);
    outs("R12 base");
    memSize = 2'd2;

    // R11 graphics registers
    wr(16'h03CE, 8'h0C);
    wr(16'h03CF, 8'h00);
    rd(16'h03CF, "R11 gdc 0x0C");
    wr(16'h03CE, 8'h45);
    wr(16'h03CF, 8'h99);
    rd(16'h03CF, "R11 out of range");
    rd(16'h03CE, "R11 idx 8bit");

    // R3 / R4 banks
    wr(16'h03D7, 8'hF3);
    wr(16'h03D6, 8'h0A);
    outs("R4 shared");
    wr(16'h03CE, 8'h0F);
    wr(16'h03CF, 8'h04);
    outs("R4 split");
    rd(16'h03D6, "R4 bankRd 8bit");

    // R13 undecoded port
    rd(16'h03C0, "R13 undecoded");

    // R2 monochrome relocation
    wr(16'h03C2, 8'h00);
    rd(16'h03D4, "R2 colour port gone");
    wr(16'h03B4, 8'h03);
    rd(16'h03B5, "R2 mono crtc data");
    wr(16'h03B7, 8'h05);
    outs("R2 mono bank");
    rd(16'h03CC, "R2 misc");
    wr(16'h03C2, 8'h01);
    rd(16'h03B4, "R2 mono port gone");

    // Randomized mix
    void'($urandom(32'h1D5E_0042));
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 9));
      logic [7:0] d = 8'($urandom);
      case (op)
        0: wr(16'h03D4, 8'($urandom_range(0, 63)));
        1: wr(16'h03D5, d);
        2: wr(16'h03CE, 8'($urandom_range(0, 71)));
        3: wr(16'h03CF, d);
        4: wr(16'h03D6, d);
        5: wr(16'h03D7, d);
        6: rd(16'h03D5, "R6 R7 R8 random crtc");
        7: rd(16'h03CF, "R11 random gdc");
        8: rd(16'h03D4, "R5 random idx");
        default: begin
          if (n % 5 == 0) memSize = 2'($urandom);
          outs("R3 R4 random");
        end
      endcase
    end

    finishRun();
  end

endmodule